// File: doc/BRIEF.md
# Zero-Acknowledge Command Mailbox Pair

This block carries commands between a host sequencer and a processing engine through two small register mailboxes, one for each direction. Each mailbox has a command slot at index 0 and argument slots at the other indices. A sender fills in the arguments first and then writes a nonzero code into the command slot. That write marks the mailbox as pending for the other side. The recipient reads the command and its arguments, then acknowledges by writing zero into the command slot. No separate handshake bits exist. A command slot that reads zero means the previous command has been consumed and the mailbox may be used again.

Each side has one register port made of a write enable, an address and write data, plus a read data output. The top address bit chooses which mailbox the access reaches: the side's own outbound mailbox or its inbound one. Each side also sees three flags: whether its outbound mailbox is free, whether its inbound mailbox holds a pending command, and a sticky overrun bit. The overrun bit records that the side tried to write its outbound mailbox while that mailbox was still busy.

Top module: `cmd_mailbox_pair`

## Requirements
- R1: After reset every slot of both mailboxes reads 0, both free flags are 1, both pending flags are 0 and both overrun flags are 0.
- R2: Address bit ADDR_W-1 selects the mailbox: 0 is the side's own outbound mailbox, 1 is its inbound mailbox. The low IDX_W bits select the slot, with index 0 as the command slot. The read data output shows the addressed slot combinationally.
- R3: While the command slot of a mailbox is zero, its sender may write any slot. The value can be read from the next cycle by both sides.
- R4: A nonzero sender write to index 0 of a free mailbox makes the recipient's pending flag 1 and the sender's free flag 0 from the next cycle.
- R5: Any sender write to a mailbox whose command slot is nonzero is dropped, and every slot keeps its value.
- R6: A dropped write of R5 sets the sender's overrun flag in the next cycle. The flag then stays at 1 until reset.
- R7: A recipient write of zero to index 0 of its inbound mailbox clears the command slot. From the next cycle the pending flag is 0 and the sender's free flag is 1. Argument slots keep their values.
- R8: Every other recipient write to its inbound mailbox is ignored. This covers a nonzero value to index 0 and any value to an argument slot.
- R9: When a recipient's zero write to index 0 and a sender's write to index 0 of the same mailbox fall in the same cycle, the command slot holds 0 afterwards. The overrun rule of R6 still applies to the sender's write.
- R10: The two mailboxes are independent. Traffic in one direction changes neither the slots nor the flags of the other.
- R11: A sender write of zero to index 0 of a free mailbox leaves that mailbox free and not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host write enable |
| h_addr | input | ADDR_W | Host address: mailbox select bit and slot index |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data of the addressed slot |
| h_tx_free | output | 1 | Host-to-engine command slot is zero |
| h_rx_pend | output | 1 | Engine-to-host command slot is nonzero |
| h_ovr | output | 1 | Sticky: host wrote its busy outbound mailbox |
| e_we | input | 1 | Engine write enable |
| e_addr | input | ADDR_W | Engine address: mailbox select bit and slot index |
| e_wdata | input | DATA_W | Engine write data |
| e_rdata | output | DATA_W | Engine read data of the addressed slot |
| e_tx_free | output | 1 | Engine-to-host command slot is zero |
| e_rx_pend | output | 1 | Host-to-engine command slot is nonzero |
| e_ovr | output | 1 | Sticky: engine wrote its busy outbound mailbox |

## Verification
The bench builds the block with its defaults: DATA_W of 16 and DEPTH of 16, which gives a 5-bit address. With these values all fifteen argument slots and the command slot of both mailboxes are reachable from both ports. Random traffic then often produces same-cycle post/acknowledge collisions, writes into busy mailboxes and zero posts. Directed sequences pin down the literal outcome of each of these collisions, including the sticky overrun bit across a reset.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    // Meaning of the top address bit on each side's port
    typedef enum logic {
        SEL_OUTBOX = 1'b0,
        SEL_INBOX  = 1'b1
    } mbox_sel_e;

    localparam int SIDE_HOST = 0;
    localparam int SIDE_ENG  = 1;
    localparam int N_SIDES   = 2;
endpackage

// File: rtl/mbox_unit.sv
// One direction: a sender port that may fill the mailbox only while the
// command slot is zero, and a recipient port that may only zero the slot.
module mbox_unit #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_we,
    input  logic [IDX_W-1:0]  snd_idx,
    input  logic [DATA_W-1:0] snd_wdata,
    output logic [DATA_W-1:0] snd_rdata,
    input  logic              rcv_we,
    input  logic [IDX_W-1:0]  rcv_idx,
    input  logic [DATA_W-1:0] rcv_wdata,
    output logic [DATA_W-1:0] rcv_rdata,
    output logic              busy,
    output logic              overrun
);
    localparam logic [IDX_W-1:0] CMD_IDX = '0;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] slot;
        logic                         ovr;
    } box_state_t;

    box_state_t st_d, st_q;
    logic       cmd_live;
    logic       ack_hit;

    always_comb begin
        st_d     = st_q;
        cmd_live = |st_q.slot[CMD_IDX];
        ack_hit  = rcv_we && (rcv_idx == CMD_IDX) && (rcv_wdata == '0);

        if (snd_we) begin
            if (cmd_live) begin
                st_d.ovr = 1'b1;
            end else if (!(ack_hit && snd_idx == CMD_IDX)) begin
                st_d.slot[snd_idx] = snd_wdata;
            end
        end

        // recipient clear wins over any same-cycle sender write
        if (ack_hit) begin
            st_d.slot[CMD_IDX] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign snd_rdata = st_q.slot[snd_idx];
    assign rcv_rdata = st_q.slot[rcv_idx];
    assign busy      = |st_q.slot[CMD_IDX];
    assign overrun   = st_q.ovr;
endmodule

// File: rtl/cmd_mailbox_pair.sv
module cmd_mailbox_pair #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_tx_free,
    output logic              h_rx_pend,
    output logic              h_ovr,
    input  logic              e_we,
    input  logic [ADDR_W-1:0] e_addr,
    input  logic [DATA_W-1:0] e_wdata,
    output logic [DATA_W-1:0] e_rdata,
    output logic              e_tx_free,
    output logic              e_rx_pend,
    output logic              e_ovr
);
    import mbox_pkg::*;

    // per-side port view; mailbox u is sent by side u
    logic              p_we  [N_SIDES];
    mbox_sel_e         p_sel [N_SIDES];
    logic [IDX_W-1:0]  p_idx [N_SIDES];
    logic [DATA_W-1:0] p_wd  [N_SIDES];
    logic [DATA_W-1:0] p_rd  [N_SIDES];

    logic [DATA_W-1:0] u_srd [N_SIDES];
    logic [DATA_W-1:0] u_rrd [N_SIDES];
    logic              u_busy[N_SIDES];
    logic              u_ovr [N_SIDES];

    assign p_we[SIDE_HOST]  = h_we;
    assign p_sel[SIDE_HOST] = mbox_sel_e'(h_addr[ADDR_W-1]);
    assign p_idx[SIDE_HOST] = h_addr[IDX_W-1:0];
    assign p_wd[SIDE_HOST]  = h_wdata;
    assign p_we[SIDE_ENG]   = e_we;
    assign p_sel[SIDE_ENG]  = mbox_sel_e'(e_addr[ADDR_W-1]);
    assign p_idx[SIDE_ENG]  = e_addr[IDX_W-1:0];
    assign p_wd[SIDE_ENG]   = e_wdata;

    for (genvar u = 0; u < N_SIDES; u++) begin : g_box
        localparam int PEER = N_SIDES - 1 - u;

        mbox_unit #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH),
            .IDX_W  (IDX_W)
        ) u_box (
            .clk       (clk),
            .rst_n     (rst_n),
            .snd_we    (p_we[u] && (p_sel[u] == SEL_OUTBOX)),
            .snd_idx   (p_idx[u]),
            .snd_wdata (p_wd[u]),
            .snd_rdata (u_srd[u]),
            .rcv_we    (p_we[PEER] && (p_sel[PEER] == SEL_INBOX)),
            .rcv_idx   (p_idx[PEER]),
            .rcv_wdata (p_wd[PEER]),
            .rcv_rdata (u_rrd[u]),
            .busy      (u_busy[u]),
            .overrun   (u_ovr[u])
        );

        assign p_rd[u] = (p_sel[u] == SEL_INBOX) ? u_rrd[PEER] : u_srd[u];
    end

    assign h_rdata   = p_rd[SIDE_HOST];
    assign e_rdata   = p_rd[SIDE_ENG];
    assign h_tx_free = !u_busy[SIDE_HOST];
    assign e_rx_pend = u_busy[SIDE_HOST];
    assign e_tx_free = !u_busy[SIDE_ENG];
    assign h_rx_pend = u_busy[SIDE_ENG];
    assign h_ovr     = u_ovr[SIDE_HOST];
    assign e_ovr     = u_ovr[SIDE_ENG];
endmodule

// File: rtl/cmd_mailbox_pair_chk.sv
module cmd_mailbox_pair_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int ADDR_W = IDX_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_we,
    input logic [ADDR_W-1:0] h_addr,
    input logic [DATA_W-1:0] h_wdata,
    input logic              h_tx_free,
    input logic              h_rx_pend,
    input logic              h_ovr,
    input logic              e_we,
    input logic [ADDR_W-1:0] e_addr,
    input logic [DATA_W-1:0] e_wdata,
    input logic              e_tx_free,
    input logic              e_rx_pend,
    input logic              e_ovr
);
    localparam logic [ADDR_W-1:0] OUT_CMD = '0;
    localparam logic [ADDR_W-1:0] IN_CMD  = {1'b1, {IDX_W{1'b0}}};

    logic h_snd, e_snd, h_post, e_post, e_ack, h_ack;
    assign h_snd  = h_we && !h_addr[ADDR_W-1];
    assign e_snd  = e_we && !e_addr[ADDR_W-1];
    assign h_post = h_we && (h_addr == OUT_CMD) && (h_wdata != '0);
    assign e_post = e_we && (e_addr == OUT_CMD) && (e_wdata != '0);
    assign e_ack  = e_we && (e_addr == IN_CMD) && (e_wdata == '0);
    assign h_ack  = h_we && (h_addr == IN_CMD) && (h_wdata == '0);

    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (h_tx_free && e_tx_free && !h_rx_pend && !e_rx_pend && !h_ovr && !e_ovr));

    p_post_pends_h_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (h_tx_free && h_post && !e_ack) |=> (e_rx_pend && !h_tx_free));
    p_post_pends_e_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (e_tx_free && e_post && !h_ack) |=> (h_rx_pend && !e_tx_free));

    p_busy_holds_h_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_tx_free && !e_ack) |=> !h_tx_free);
    p_busy_holds_e_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_tx_free && !h_ack) |=> !e_tx_free);

    p_busy_write_ovr_h_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_snd && !h_tx_free) |=> h_ovr);
    p_busy_write_ovr_e_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (e_snd && !e_tx_free) |=> e_ovr);
    p_ovr_sticky_h_r6: assert property (@(posedge clk) disable iff (!rst_n)
        h_ovr |=> h_ovr);
    p_ovr_sticky_e_r6: assert property (@(posedge clk) disable iff (!rst_n)
        e_ovr |=> e_ovr);

    p_ack_frees_h_r7: assert property (@(posedge clk) disable iff (!rst_n)
        e_ack |=> (h_tx_free && !e_rx_pend));
    p_ack_frees_e_r7: assert property (@(posedge clk) disable iff (!rst_n)
        h_ack |=> (e_tx_free && !h_rx_pend));

    p_no_sender_stays_h_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_snd && !e_ack) |=> $stable(h_tx_free));
    p_no_sender_stays_e_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_snd && !h_ack) |=> $stable(e_tx_free));
endmodule

bind cmd_mailbox_pair cmd_mailbox_pair_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_we      (h_we),
    .h_addr    (h_addr),
    .h_wdata   (h_wdata),
    .h_tx_free (h_tx_free),
    .h_rx_pend (h_rx_pend),
    .h_ovr     (h_ovr),
    .e_we      (e_we),
    .e_addr    (e_addr),
    .e_wdata   (e_wdata),
    .e_tx_free (e_tx_free),
    .e_rx_pend (e_rx_pend),
    .e_ovr     (e_ovr)
);

// File: tb/cmd_mailbox_pair_bench.sv
module cmd_mailbox_pair_bench;
    localparam int CLK_P = 10;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int IW    = 4;
    localparam int AW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          h_we = 1'b0, e_we = 1'b0;
    logic [AW-1:0] h_addr = '0, e_addr = '0;
    logic [DW-1:0] h_wdata = '0, e_wdata = '0;
    logic [DW-1:0] h_rdata, e_rdata;
    logic          h_tx_free, h_rx_pend, h_ovr, e_tx_free, e_rx_pend, e_ovr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DW-1:0] mdl [2][DEPTH];
    bit            mdl_ovr [2];

    always #(CLK_P/2) clk = ~clk;

    cmd_mailbox_pair u_cmd_mailbox_pair (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .h_tx_free(h_tx_free), .h_rx_pend(h_rx_pend), .h_ovr(h_ovr),
        .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata), .e_rdata(e_rdata),
        .e_tx_free(e_tx_free), .e_rx_pend(e_rx_pend), .e_ovr(e_ovr)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ad(bit inbox, int idx);
        logic [IW-1:0] i = idx[IW-1:0];
        return {inbox, i};
    endfunction

    // side 0 host, side 1 engine; mailbox m is sent by side m
    function automatic logic [DW-1:0] mdl_read(int side, logic [AW-1:0] a);
        int mb = a[AW-1] ? 1 - side : side;
        return mdl[mb][a[IW-1:0]];
    endfunction

    task automatic mdl_update(bit hw, logic [AW-1:0] ha, logic [DW-1:0] hd,
                              bit ew, logic [AW-1:0] ea, logic [DW-1:0] ed);
        bit            we [2];
        logic [AW-1:0] a  [2];
        logic [DW-1:0] d  [2];
        we[0] = hw; a[0] = ha; d[0] = hd;
        we[1] = ew; a[1] = ea; d[1] = ed;
        for (int mb = 0; mb < 2; mb++) begin
            int  pr   = 1 - mb;
            bit  snd  = we[mb] && !a[mb][AW-1];
            bit  clr  = we[pr] && a[pr][AW-1] && (a[pr][IW-1:0] == 0) && (d[pr] == 0);
            bit  busy = (mdl[mb][0] != 0);
            if (snd) begin
                if (busy) mdl_ovr[mb] = 1'b1;
                else if (!(clr && a[mb][IW-1:0] == 0)) mdl[mb][a[mb][IW-1:0]] = d[mb];
            end
            if (clr) mdl[mb][0] = '0;
        end
    endtask

    task automatic check_flags(string tag);
        check(tag, "h_tx_free", h_tx_free, (mdl[0][0] == 0));
        check(tag, "e_rx_pend", e_rx_pend, (mdl[0][0] != 0));
        check(tag, "e_tx_free", e_tx_free, (mdl[1][0] == 0));
        check(tag, "h_rx_pend", h_rx_pend, (mdl[1][0] != 0));
        check(tag, "h_ovr", h_ovr, mdl_ovr[0]);
        check(tag, "e_ovr", e_ovr, mdl_ovr[1]);
    endtask

    task automatic step(string tag, bit hw, logic [AW-1:0] ha, logic [DW-1:0] hd,
                        bit ew, logic [AW-1:0] ea, logic [DW-1:0] ed);
        @(negedge clk);
        h_we = hw; h_addr = ha; h_wdata = hd;
        e_we = ew; e_addr = ea; e_wdata = ed;
        #1;
        check(tag, "host read", h_rdata, mdl_read(0, ha));
        check(tag, "engine read", e_rdata, mdl_read(1, ea));
        @(posedge clk);
        mdl_update(hw, ha, hd, ew, ea, ed);
        #1;
        check_flags(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        h_we = 1'b0; e_we = 1'b0;
        repeat (3) @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            mdl_ovr[m] = 1'b0;
            for (int i = 0; i < DEPTH; i++) mdl[m][i] = '0;
        end
        #1;
        check_flags("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd24601);

        // R1: reset state, all slots read zero through both ports
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            step("R1", 0, ad(0, i), 0, 0, ad(1, i), 0);
            check("R1", "host outbox slot", h_rdata, 0);
        end

        // R3 / R2: host fills arguments, engine reads them via its inbox
        for (int i = 1; i < 4; i++) step("R3", 1, ad(0, i), DW'(16'h1000 + i), 0, ad(1, i), 0);
        step("R2", 0, ad(0, 2), 0, 0, ad(1, 2), 0);
        check("R2", "engine inbox arg2", e_rdata, 32'h1002);

        // R11: zero post keeps mailbox free
        step("R11", 1, ad(0, 0), 0, 0, ad(0, 0), 0);
        check("R11", "h_tx_free", h_tx_free, 1);

        // R4: post
        step("R4", 1, ad(0, 0), 16'h0042, 0, ad(0, 0), 0);
        check("R4", "e_rx_pend", e_rx_pend, 1);
        check("R4", "h_tx_free", h_tx_free, 0);

        // R5 / R6: write into busy mailbox dropped, overrun set
        step("R5", 1, ad(0, 2), 16'hdead, 0, ad(1, 2), 0);
        check("R6", "h_ovr", h_ovr, 1);
        step("R5", 0, ad(0, 2), 0, 0, ad(1, 2), 0);
        check("R5", "arg2 unchanged", e_rdata, 32'h1002);

        // R8: engine nonzero to cmd and write to argument are ignored
        step("R8", 0, ad(0, 0), 0, 1, ad(1, 0), 16'h0001);
        step("R8", 0, ad(0, 1), 0, 1, ad(1, 1), 16'h7777);
        step("R8", 0, ad(0, 1), 0, 0, ad(1, 0), 0);
        check("R8", "arg1 kept", h_rdata, 32'h1001);
        check("R8", "cmd kept", e_rdata, 32'h0042);

        // R10: engine posts its own command while host mailbox busy
        step("R10", 0, ad(1, 0), 0, 1, ad(0, 0), 16'h0abc);
        check("R10", "h_rx_pend", h_rx_pend, 1);
        check("R10", "e_ovr", e_ovr, 0);

        // R7: engine acknowledges, arguments retained
        step("R7", 0, ad(0, 3), 0, 1, ad(1, 0), 0);
        check("R7", "h_tx_free", h_tx_free, 1);
        check("R7", "e_rx_pend", e_rx_pend, 0);
        check("R7", "h_rx_pend still", h_rx_pend, 1);
        step("R7", 0, ad(0, 3), 0, 0, ad(1, 3), 0);
        check("R7", "arg3 kept", e_rdata, 32'h1003);

        // R6: overrun sticky, cleared only by reset
        check("R6", "h_ovr sticky", h_ovr, 1);
        do_reset();
        check("R1", "h_ovr after reset", h_ovr, 0);

        // R9: post and clear in the same cycle on a free mailbox
        step("R9", 1, ad(0, 0), 16'h0007, 1, ad(1, 0), 0);
        check("R9", "h_tx_free", h_tx_free, 1);
        check("R9", "h_ovr", h_ovr, 0);
        // R9: busy mailbox, post and clear together
        step("R9", 1, ad(0, 0), 16'h0005, 0, ad(0, 0), 0);
        step("R9", 1, ad(0, 0), 16'h0009, 1, ad(1, 0), 0);
        check("R9", "h_tx_free", h_tx_free, 1);
        check("R9", "h_ovr", h_ovr, 1);

        // constrained random traffic
        do_reset();
        for (int n = 0; n < 1200; n++) begin
            bit            hw, ew;
            logic [AW-1:0] ha, ea;
            logic [DW-1:0] hd, ed;
            if (n == 600) do_reset();
            hw = ($urandom_range(0, 2) != 0);
            ew = ($urandom_range(0, 2) != 0);
            ha = ad($urandom_range(0, 1), ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(0, DEPTH - 1));
            ea = ad($urandom_range(0, 1), ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(0, DEPTH - 1));
            hd = ($urandom_range(0, 2) == 0) ? '0 : DW'($urandom);
            ed = ($urandom_range(0, 2) == 0) ? '0 : DW'($urandom);
            step("R10", hw, ha, hd, ew, ea, ed);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule